// File: doc/BRIEF.md
# Signed/Unsigned Widening Multiplier

This unit multiplies two integer operands over several clock cycles and returns a product of twice the operand width. It serves an accumulator-style CPU datapath. One datapath handles both signed and unsigned operands; a per-operation sign input chooses between them. The operand width is 8, 16, 32 or 64 bits, chosen by a two-bit code. Operands are zero-extended or sign-extended from that width before the multiply.

The product comes back as a low half and a high half on separate outputs. Two flags come with it, overflow and carry, and both are derived from the high half. A mode input selects the form of the result. In the widening form both halves are delivered. In the truncating form only the low half is delivered, but the flags still report whether information was lost. In the byte-width widening form the whole 16-bit product lands in the low result: the high byte sits in bits 15:8, because that form writes the high byte into the upper byte of a 16-bit accumulator.

An operation starts with a one-cycle start strobe. It finishes with a one-cycle done pulse, and the outputs are valid from that pulse until the next one.

Top module: `widening_mul`

## Requirements
- R1: After reset, busy, done, of and cf are 0, and lo and hi are all zeros.
- R2: The width code selects W: 0 gives 8, 1 gives 16, 2 gives 32 and 3 gives 64 bits. Operand bits at W and above have no effect on any result.
- R3: With sgn=0, both operands are taken as unsigned W-bit values. In widening mode (keep_hi=1) with W of 16 or more, lo holds product bits W-1:0 and hi holds product bits 2W-1:W. Bits of lo and hi at W and above are 0.
- R4: With sgn=1, both operands are taken as two's-complement W-bit values. The product is the signed 2W-bit value, placed in lo and hi as in R3.
- R5: In widening mode with W=8, lo[15:0] holds the whole 16-bit product, high byte in lo[15:8]. The rest of lo is 0, and hi is 0.
- R6: In truncating mode (keep_hi=0), lo holds product bits W-1:0, all other lo bits are 0, and hi is 0. The flags are still computed from the full product.
- R7: For an unsigned operation, of and cf are both 1 exactly when product bits 2W-1:W are not all zero.
- R8: For a signed operation, of and cf are both 1 exactly when product bits 2W-1:W differ from W copies of product bit W-1.
- R9: done rises exactly W+1 clock edges after the edge that samples start, and stays high for one cycle. busy is 1 from the cycle after that start edge until done, and is 0 while done is high.
- R10: While busy is 1, start has no effect, and changes on the operand, sign, mode and width inputs do not alter the result in progress.
- R11: lo, hi, of and cf hold their values from one done pulse until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins an operation when the unit is idle |
| sgn | input | 1 | 1 for a signed multiply, 0 for unsigned |
| keep_hi | input | 1 | 1 for the widening form, 0 for the truncating form |
| wsel | input | 2 | Operand width code (0:8, 1:16, 2:32, 3:64) |
| op_a | input | XLEN | First operand |
| op_b | input | XLEN | Second operand |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: results are valid |
| lo | output | XLEN | Low half of the product |
| hi | output | XLEN | High half of the product |
| of | output | 1 | Overflow flag |
| cf | output | 1 | Carry flag, always equal to of |

## Verification
Every result (lo, hi, of, cf) appears together with done, which comes W+1 edges after the start edge: one edge per operand bit, plus one edge to apply the sign and form the result. For each operation the bench counts edges from the start edge to the first falling-edge sample that shows done high. It compares that count with W+1, and reads the four results in that same half cycle. It also samples once more a few cycles later to confirm they hold. For the ignored-start case, the bench pulses start and scrambles every input while the unit is busy, and still expects the first operation's values at the original done time.

// File: rtl/widening_mul.sv
module widening_mul #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            sgn,
  input  logic            keep_hi,
  input  logic [1:0]      wsel,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] lo,
  output logic [XLEN-1:0] hi,
  output logic            of,
  output logic            cf
);
  localparam int PW = 2 * XLEN;
  localparam int CW = $clog2(XLEN + 1);

  typedef enum logic [1:0] {IDLE, RUN, FIN} state_t;
  state_t state;

  logic [CW-1:0]   cnt;
  logic [PW-1:0]   acc, mcand;
  logic [XLEN-1:0] mplier;
  logic            neg, sgn_q, keep_q;
  logic [1:0]      wq;

  function automatic int wbits(input logic [1:0] c);
    int w;
    w = 8 << c;
    return (w > XLEN) ? XLEN : w;
  endfunction

  function automatic logic [XLEN-1:0] wmask(input int w);
    return (XLEN'(1) << w) - XLEN'(1);
  endfunction

  // operand conditioning at start: extend from W, take magnitude
  logic [XLEN-1:0] a_m, b_m, a_x, b_x, a_abs, b_abs;
  logic            a_neg, b_neg;
  int              w_in;

  always_comb begin
    w_in  = wbits(wsel);
    a_m   = op_a & wmask(w_in);
    b_m   = op_b & wmask(w_in);
    a_neg = sgn && a_m[w_in-1];
    b_neg = sgn && b_m[w_in-1];
    a_x   = a_neg ? (a_m | ~wmask(w_in)) : a_m;
    b_x   = b_neg ? (b_m | ~wmask(w_in)) : b_m;
    a_abs = a_neg ? -a_x : a_x;
    b_abs = b_neg ? -b_x : b_x;
  end

  // result shaping from the accumulated magnitude product
  logic [PW-1:0]   prod;
  logic [XLEN-1:0] lo_w, hi_w, sx;
  logic            ovf;
  int              w_q;

  always_comb begin
    w_q  = wbits(wq);
    prod = neg ? -acc : acc;
    lo_w = XLEN'(prod) & wmask(w_q);
    hi_w = XLEN'(prod >> w_q) & wmask(w_q);
    sx   = prod[w_q-1] ? wmask(w_q) : '0;
    ovf  = sgn_q ? (hi_w != sx) : (hi_w != '0);
  end

  assign busy = (state != IDLE);
  assign cf   = of;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= IDLE;
      cnt    <= '0;
      acc    <= '0;
      mcand  <= '0;
      mplier <= '0;
      neg    <= 1'b0;
      sgn_q  <= 1'b0;
      keep_q <= 1'b0;
      wq     <= '0;
      done   <= 1'b0;
      lo     <= '0;
      hi     <= '0;
      of     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        IDLE: if (start) begin
          state  <= RUN;
          cnt    <= CW'(w_in);
          acc    <= '0;
          mcand  <= PW'(a_abs);
          mplier <= b_abs;
          neg    <= a_neg ^ b_neg;
          sgn_q  <= sgn;
          keep_q <= keep_hi;
          wq     <= wsel;
        end
        RUN: begin
          if (mplier[0]) acc <= acc + mcand;
          mcand  <= mcand << 1;
          mplier <= mplier >> 1;
          cnt    <= cnt - CW'(1);
          if (cnt == CW'(1)) state <= FIN;
        end
        FIN: begin
          state <= IDLE;
          done  <= 1'b1;
          of    <= ovf;
          if (keep_q && w_q == 8) begin
            lo <= (hi_w << 8) | lo_w;
            hi <= '0;
          end else begin
            lo <= lo_w;
            hi <= keep_q ? hi_w : '0;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R6
  trunc_hi_chk: assert property (@(posedge clk) disable iff (!rst_n) (done && !keep_q) |-> hi == '0);
  // R5
  byte_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && keep_q && wq == 2'd0) |-> (hi == '0 && lo[XLEN-1:16] == '0));
  // R7
  uflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !sgn_q && keep_q && wq != 2'd0) |-> (of == (hi != '0)));
  // R8
  sflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && sgn_q && keep_q && wq == 2'd3) |-> (of == (hi != {XLEN{lo[XLEN-1]}})));
  // R10
  hold_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RUN) |=> ($stable(wq) && $stable(neg) && $stable(sgn_q) && $stable(keep_q)));
  // R11
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && $past(!done)) |-> ($stable(lo) && $stable(hi) && $stable(of)));
endmodule

// File: tb/test_widening_mul.sv
`timescale 1ns/1ps
module test_widening_mul;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, sgn = 1'b0, keep_hi = 1'b0;
  logic [1:0]  wsel = '0;
  logic [63:0] op_a = '0, op_b = '0;
  logic        busy, done, of, cf;
  logic [63:0] lo, hi;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  widening_mul #(.XLEN(64)) i_widening_mul (
    .clk(clk), .rst_n(rst_n), .start(start), .sgn(sgn), .keep_hi(keep_hi),
    .wsel(wsel), .op_a(op_a), .op_b(op_b), .busy(busy), .done(done),
    .lo(lo), .hi(hi), .of(of), .cf(cf));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input int w);
    return (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
  endfunction

  task automatic model(input logic [63:0] a, input logic [63:0] b, input logic s,
                       input logic k, input logic [1:0] wc,
                       output logic [63:0] elo, output logic [63:0] ehi, output logic eov);
    int w;
    logic [63:0] m, pl, ph;
    logic [127:0] a2, b2, p;
    w  = 8 << wc;
    m  = mk(w);
    a2 = {64'd0, a & m};
    b2 = {64'd0, b & m};
    if (s && a2[w-1]) a2 = a2 | ~((128'd1 << w) - 128'd1);
    if (s && b2[w-1]) b2 = b2 | ~((128'd1 << w) - 128'd1);
    p   = a2 * b2;
    pl  = p[63:0] & m;
    ph  = 64'(p >> w) & m;
    eov = s ? (ph != (pl[w-1] ? m : 64'd0)) : (ph != 64'd0);
    if (k && w == 8) begin
      elo = {48'd0, ph[7:0], pl[7:0]};
      ehi = '0;
    end else begin
      elo = pl;
      ehi = k ? ph : '0;
    end
  endtask

  task automatic run_op(input logic [63:0] a, input logic [63:0] b, input logic s,
                        input logic k, input logic [1:0] wc, input bit disturb);
    logic [63:0] elo, ehi;
    logic eov;
    int n, w;
    bit seen;
    string rq;
    w = 8 << wc;
    model(a, b, s, k, wc, elo, ehi, eov);
    rq = !k ? "R6" : (w == 8 ? "R5" : (s ? "R4" : "R3"));
    @(negedge clk);
    op_a = a; op_b = b; sgn = s; keep_hi = k; wsel = wc; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    op_a = $urandom; op_b = $urandom;
    n = 0; seen = 0;
    while (n < 100) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n == 2) chk("R9 busy", 64'(busy), 64'd1);
      if (disturb && n == 3) begin
        // R10 start and input changes while busy
        start = 1'b1; sgn = ~s; keep_hi = ~k; wsel = wc + 2'd1;
        op_a = {$urandom, $urandom}; op_b = {$urandom, $urandom};
      end else start = 1'b0;
      if (done) begin seen = 1; break; end
    end
    start = 1'b0;
    if (!seen) begin
      errors++; checks++;
      $display("FAIL R9 done missing actual=timeout expected=%0d", w + 1);
      return;
    end
    chk("R9 latency", 64'(n), 64'(w + 1));
    chk("R9 busy low at done", 64'(busy), 64'd0);
    chk({rq, " lo"}, lo, elo);
    chk({rq, " hi"}, hi, ehi);
    chk(s ? "R8 of" : "R7 of", 64'(of), 64'(eov));
    chk("R7 cf", 64'(cf), 64'(eov));
    if (disturb) chk("R10 lo after disturb", lo, elo);
    @(negedge clk);
    chk("R9 done pulse", 64'(done), 64'd0);
    @(negedge clk);
    chk("R11 hold lo", lo, elo);
    chk("R11 hold of", 64'(of), 64'(eov));
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_2024));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", 64'(busy), 0);
    chk("R1 done", 64'(done), 0);
    chk("R1 lo", lo, 0);
    chk("R1 hi", hi, 0);
    chk("R1 of", 64'(of), 0);
    rst_n = 1'b1;
    // directed corners
    run_op(64'hFF, 64'hFF, 0, 1, 2'd0, 0);                       // R5, R7
    run_op(64'hFF, 64'hFF, 1, 1, 2'd0, 0);                       // R5, R8
    run_op(64'hAAAA_0080, 64'h5555_0080, 1, 1, 2'd0, 0);         // R2 upper bits ignored
    run_op(64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 1, 1, 2'd3, 0); // R8 min*-1
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, 2'd3, 0); // R3
    run_op(64'h0000_7FFF, 64'h0000_0002, 1, 0, 2'd1, 0);         // R6 truncating overflow
    run_op(64'hFFFF_FFFE, 64'h0000_0003, 1, 1, 2'd2, 0);         // R4 no overflow
    run_op(64'd0, 64'h1234, 0, 1, 2'd1, 0);                      // R3 zero
    run_op(64'h1234_5678, 64'h9ABC_DEF0, 0, 1, 2'd2, 1);         // R10
    run_op(64'h80, 64'h7F, 1, 0, 2'd0, 1);                       // R10, R6
    // constrained random
    for (int i = 0; i < 300; i++) begin
      logic [63:0] a, b;
      int pick;
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      pick = $urandom_range(0, 7);
      if (pick == 0) a = 64'h1 << $urandom_range(0, 63);
      if (pick == 1) b = '1;
      if (pick == 2) a = 64'h0;
      run_op(a, b, 1'($urandom), 1'($urandom), 2'($urandom), (i % 17) == 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule